// File: doc/BRIEF.md
# Paired-Bit Block Load Sender

This block streams a buffer of bytes to a host over a two-line open-collector serial bus: a data line and a clock line, plus an attention line from the host. The host reads in a fast block-load mode. After a start strobe the block announces itself by pulling data low and leaving clock released for a lead-in period. It then serves the buffer one byte at a time. For each byte it releases both lines and waits for the host to request the byte, which the host does by pulling data or attention low. After a short setup it sends the byte as four timed slots, two bits per slot. When the last byte is out it shows an OK status and waits for the host to acknowledge.

If the end flag was given, an end-of-file mark follows the acknowledge. The mark is three equal phases on the clock line: held low, released, then low again. The block then releases the clock. If attention falls while the OK status is shown, the transfer ends at once and no mark is sent. A zero-length request goes directly to the end-of-file mark. Bytes come from an external synchronous read port addressed by the byte index. Completion is reported with a one-cycle strobe and a flag that tells whether attention ended the transfer.

Every duration is a parameter in clock cycles. The bus inputs are passed through a synchronizer before they are used.

Top module: `pairbit_block_sender`

## Requirements
- R1: After reset and while idle, both pull outputs are 0, `fetch_en_o` is 0, `done_o` is 0 and `atn_abort_o` is 0.
- R2: When `start_i` is sampled high in idle with a nonzero `len_i`, then from the next cycle on, `data_pull_o`=1 and `clk_pull_o`=0 for `LEAD_CYC` cycles.
- R3: In a request wait both pulls are 0. A request is a low level on data or attention. It is accepted no earlier than `SYNC_STAGES`+1 cycles after the wait begins, and `SYNC_STAGES` cycles after the line is seen low.
- R4: Each accepted request raises `fetch_en_o` for exactly one cycle, the cycle before the setup begins. `fetch_addr_o` equals the byte index: 0, 1, … up to `len_i`-1, in order. Read data is expected on `fetch_data_i` one cycle later.
- R5: After `SETUP_CYC` cycles with both lines released, the byte goes out in four slots of `SLOT_CYC` cycles each. Slot j (j=0..3) sets `clk_pull_o` = NOT bit 2j and `data_pull_o` = NOT bit 2j+1.
- R6: The last slot's levels are held for `POST_CYC` cycles. The block then waits for the next request, or shows OK after the final byte.
- R7: OK status is `clk_pull_o`=1 and `data_pull_o`=0. It holds until data is seen low, with the same settle and latency as in R3.
- R8: Attention seen low during OK ends the transfer in the following cycle, with `done_o`=1 and `atn_abort_o`=1 and no end-of-file mark. Attention takes priority over data.
- R9: After an acknowledged OK with the end flag set, `clk_pull_o` is 1, then 0, then 1, for `EOF_CYC` cycles each. Data stays released. Then both lines are released and `done_o` pulses.
- R10: After an acknowledged OK with the end flag clear, the OK levels are held for `TAIL_CYC` cycles, then `done_o` pulses.
- R11: A start with `len_i`=0 runs the R9 mark from the next cycle, whatever the end flag, and fetches nothing.
- R12: `start_i` is ignored while a transfer runs. `done_o` is a single-cycle pulse. `atn_abort_o` holds its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled in idle |
| len_i | input | LEN_W | Number of bytes in the buffer |
| eof_i | input | 1 | Send the end-of-file mark after the block |
| fetch_en_o | output | 1 | Read enable of the byte source |
| fetch_addr_o | output | LEN_W | Byte index to read |
| fetch_data_i | input | 8 | Read data, valid one cycle after the enable |
| data_line_i | input | 1 | Level of the data line (0 = low) |
| atn_line_i | input | 1 | Level of the attention line (0 = low) |
| data_pull_o | output | 1 | 1 pulls the data line low |
| clk_pull_o | output | 1 | 1 pulls the clock line low |
| done_o | output | 1 | One-cycle completion strobe |
| atn_abort_o | output | 1 | Last transfer was ended by attention |

## Verification
Each transfer is laid out ahead of time as a per-cycle table of host stimulus and expected outputs, built from the parameter values. Lead-in, setup, slot, hold, tail and mark phases each last their exact parameter count. They start in the cycle after the edge that leaves the previous phase. A request or acknowledge applied k cycles into a wait is answered at edge max(`SYNC_STAGES`+1, k+`SYNC_STAGES`) counted from the wait's first cycle. The fetch enable comes one cycle earlier. `done_o` appears in the cycle after the final phase's last cycle. The table is compared 1 ns after every rising edge, so each comparison sees settled register outputs for exactly the cycle it describes.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LEAD, ST_WAIT_REQ, ST_SETUP, ST_SEND, ST_POST,
    ST_OK, ST_EOF_HOLD, ST_EOF_REL, ST_EOF_PULL, ST_TAIL
  } pbs_state_e;

  function automatic int unsigned pbs_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= '1;  // idle bus is high
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pbs_pair_ser.sv
module pbs_pair_ser (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       shift_i,
  output logic [1:0] pair_o   // [0] clock level, [1] data level
);
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= 8'hFF;
    else if (load_i)   sh_q <= data_i;
    else if (shift_i)  sh_q <= {2'b11, sh_q[7:2]};
  end

  assign pair_o = sh_q[1:0];
endmodule

// File: rtl/pairbit_block_sender.sv
module pairbit_block_sender
  import pbs_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_CYC    = 11800,
  parameter int unsigned SETUP_CYC   = 1600,
  parameter int unsigned SLOT_CYC    = 2080,
  parameter int unsigned POST_CYC    = 1400,
  parameter int unsigned EOF_CYC     = 18800,
  parameter int unsigned TAIL_CYC    = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             eof_i,
  output logic             fetch_en_o,
  output logic [LEN_W-1:0] fetch_addr_o,
  input  logic [7:0]       fetch_data_i,
  input  logic             data_line_i,
  input  logic             atn_line_i,
  output logic             data_pull_o,
  output logic             clk_pull_o,
  output logic             done_o,
  output logic             atn_abort_o
);
  localparam int unsigned MAXC = pbs_max(pbs_max(pbs_max(LEAD_CYC, SETUP_CYC),
                                 pbs_max(SLOT_CYC, POST_CYC)),
                                 pbs_max(pbs_max(EOF_CYC, TAIL_CYC), SYNC_STAGES));
  localparam int unsigned TW = $clog2(MAXC + 1);
  localparam int unsigned NSLOT = 4;

  pbs_state_e       st_q, st_d;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             eof_q, fetch_pend_q, done_q, abort_q;
  logic [1:0]       slot_q;
  logic [1:0]       line_s;
  logic             data_low, atn_low, req_seen;
  logic             tmr_ld, tmr_zero, ser_shift, fin, fin_abort;
  logic [TW-1:0]    tmr_val;
  logic [1:0]       pair;
  logic             sending;

  pbs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i, .rst_ni, .d_i({atn_line_i, data_line_i}), .q_o(line_s));

  pbs_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_ld), .val_i(tmr_val), .zero_o(tmr_zero));

  pbs_pair_ser u_ser (
    .clk_i, .rst_ni, .load_i(fetch_pend_q), .data_i(fetch_data_i),
    .shift_i(ser_shift), .pair_o(pair));

  assign data_low = ~line_s[0];
  assign atn_low  = ~line_s[1];
  // timer doubles as settle guard so stale synchronizer samples are skipped
  assign req_seen = (st_q == ST_WAIT_REQ) && tmr_zero && (data_low || atn_low);

  always_comb begin
    st_d      = st_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    ser_shift = 1'b0;
    fin       = 1'b0;
    fin_abort = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        tmr_ld = 1'b1;
        if (len_i == '0) begin st_d = ST_EOF_HOLD; tmr_val = TW'(EOF_CYC - 1); end
        else             begin st_d = ST_LEAD;     tmr_val = TW'(LEAD_CYC - 1); end
      end
      ST_LEAD: if (tmr_zero) begin
        st_d = ST_WAIT_REQ; tmr_ld = 1'b1; tmr_val = TW'(SYNC_STAGES);
      end
      ST_WAIT_REQ: if (req_seen) begin
        st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmr_zero) begin
        st_d = ST_SEND; tmr_ld = 1'b1; tmr_val = TW'(SLOT_CYC - 1);
      end
      ST_SEND: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (slot_q == 2'(NSLOT - 1)) begin st_d = ST_POST; tmr_val = TW'(POST_CYC - 1); end
        else begin ser_shift = 1'b1; tmr_val = TW'(SLOT_CYC - 1); end
      end
      ST_POST: if (tmr_zero) begin
        tmr_ld = 1'b1; tmr_val = TW'(SYNC_STAGES);
        st_d = (idx_q == len_q) ? ST_OK : ST_WAIT_REQ;
      end
      ST_OK: if (tmr_zero) begin
        if (atn_low) begin
          st_d = ST_IDLE; fin = 1'b1; fin_abort = 1'b1;
        end else if (data_low) begin
          tmr_ld = 1'b1;
          if (eof_q) begin st_d = ST_EOF_HOLD; tmr_val = TW'(EOF_CYC - 1); end
          else       begin st_d = ST_TAIL;     tmr_val = TW'(TAIL_CYC - 1); end
        end
      end
      ST_EOF_HOLD: if (tmr_zero) begin
        st_d = ST_EOF_REL; tmr_ld = 1'b1; tmr_val = TW'(EOF_CYC - 1);
      end
      ST_EOF_REL: if (tmr_zero) begin
        st_d = ST_EOF_PULL; tmr_ld = 1'b1; tmr_val = TW'(EOF_CYC - 1);
      end
      ST_EOF_PULL, ST_TAIL: if (tmr_zero) begin
        st_d = ST_IDLE; fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      len_q        <= '0;
      eof_q        <= 1'b0;
      idx_q        <= '0;
      slot_q       <= '0;
      fetch_pend_q <= 1'b0;
      done_q       <= 1'b0;
      abort_q      <= 1'b0;
    end else begin
      st_q         <= st_d;
      fetch_pend_q <= req_seen;
      done_q       <= fin;
      if (st_q == ST_IDLE && start_i) begin
        len_q   <= len_i;
        eof_q   <= eof_i;
        idx_q   <= '0;
        abort_q <= 1'b0;
      end
      if (fin) abort_q <= fin_abort;
      if (req_seen) idx_q <= idx_q + 1'b1;
      if (st_q == ST_SETUP) slot_q <= '0;
      else if (ser_shift) slot_q <= slot_q + 1'b1;
    end
  end

  assign sending      = (st_q == ST_SEND) || (st_q == ST_POST);
  assign fetch_en_o   = req_seen;
  assign fetch_addr_o = idx_q;
  assign data_pull_o  = (st_q == ST_LEAD) || (sending && !pair[1]);
  assign clk_pull_o   = (sending && !pair[0]) || (st_q == ST_OK) || (st_q == ST_TAIL) ||
                        (st_q == ST_EOF_HOLD) || (st_q == ST_EOF_PULL);
  assign done_o       = done_q;
  assign atn_abort_o  = abort_q;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker
  import pbs_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input pbs_state_e       st_q,
  input logic             tmr_zero,
  input logic [LEN_W-1:0] len_q,
  input logic             fetch_en_o,
  input logic [LEN_W-1:0] fetch_addr_o,
  input logic             data_pull_o,
  input logic             clk_pull_o,
  input logic             done_o,
  input logic             atn_abort_o
);
  a_r1_idle_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !fetch_en_o);

  a_r4_fetch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |=> !fetch_en_o);

  a_r4_fetch_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_en_o |-> (fetch_addr_o < len_q));

  a_r5_slot_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && $past(st_q) == ST_SEND && !$past(tmr_zero))
      |-> $stable({data_pull_o, clk_pull_o}));

  a_r7_ok_settles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OK && !tmr_zero) |=> (st_q == ST_OK));

  a_r8_abort_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atn_abort_o) |-> done_o);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind pairbit_block_sender pbs_checker #(.LEN_W(LEN_W)) u_pbs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_q(st_q), .tmr_zero(tmr_zero), .len_q(len_q),
  .fetch_en_o(fetch_en_o), .fetch_addr_o(fetch_addr_o), .data_pull_o(data_pull_o),
  .clk_pull_o(clk_pull_o), .done_o(done_o), .atn_abort_o(atn_abort_o));

// File: tb/pairbit_block_sender_test.sv
`timescale 1ns/1ps
module pairbit_block_sender_test;
  localparam int S   = 2;
  localparam int TL  = 12;
  localparam int TSU = 3;
  localparam int TSL = 5;
  localparam int TP  = 4;
  localparam int TE  = 7;
  localparam int TT  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, eof = 1'b0, hd = 1'b1, ha = 1'b1;
  logic [7:0] len = '0;
  logic fetch_en, data_pull, clk_pull, done, abort;
  logic [7:0] fetch_addr, fetch_q;
  logic [7:0] mem [256];
  logic data_line, atn_line;
  int vec = 0, bad = 0;
  bit finished = 0;
  bit cur_abort = 0;

  bit    q_st[$], q_hd[$], q_ha[$], q_ef[$], q_dp[$], q_cp[$], q_fe[$], q_dn[$], q_ab[$];
  int    q_len[$], q_fa[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  assign data_line = hd & ~data_pull;   // wired-AND bus
  assign atn_line  = ha;

  always @(posedge clk) if (fetch_en) fetch_q <= mem[fetch_addr];

  pairbit_block_sender #(
    .LEN_W(8), .SYNC_STAGES(S), .LEAD_CYC(TL), .SETUP_CYC(TSU), .SLOT_CYC(TSL),
    .POST_CYC(TP), .EOF_CYC(TE), .TAIL_CYC(TT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .eof_i(eof),
    .fetch_en_o(fetch_en), .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_q),
    .data_line_i(data_line), .atn_line_i(atn_line),
    .data_pull_o(data_pull), .clk_pull_o(clk_pull), .done_o(done), .atn_abort_o(abort));

  task automatic push(bit st, int ln, bit ef, bit h_d, bit h_a, bit dp, bit cp,
                      bit fe, int fa, bit dn, string tag);
    q_st.push_back(st); q_len.push_back(ln); q_ef.push_back(ef);
    q_hd.push_back(h_d); q_ha.push_back(h_a); q_dp.push_back(dp); q_cp.push_back(cp);
    q_fe.push_back(fe); q_fa.push_back(fa); q_dn.push_back(dn); q_ab.push_back(cur_abort);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) push(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, tag);
  endtask

  // R9 / R11: clock low, released, low, each TE cycles, then done
  task automatic eof_mark(bit with_start, int ln, bit ef, string tag);
    for (int i = 0; i < TE; i++) push(with_start && i == 0, ln, ef, 1, 1, 0, 1, 0, 0, 0, tag);
    for (int i = 0; i < TE; i++) push(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < TE; i++) push(0, 0, 0, 1, 1, 0, 1, 0, 0, 0, tag);
    push(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R12");
  endtask

  task automatic xfer(int ln, bit ef, int dreq, bit req_atn, int dok, bit ok_atn, bit noise);
    int kr, ko;
    logic [7:0] b;
    kr = (S + 1 > dreq + S) ? S + 1 : dreq + S;
    ko = (S + 1 > dok + S) ? S + 1 : dok + S;
    cur_abort = 0;
    if (ln == 0) begin
      eof_mark(1, ln, ef, "R11");
    end else begin
      for (int i = 0; i < TL; i++) begin
        if (i == 0) push(1, ln, ef, 1, 1, 1, 0, 0, 0, 0, "R2");
        else if (noise && i == 2) push(1, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R12");
        else push(0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R2");
      end
      for (int n = 0; n < ln; n++) begin
        b = mem[n];
        for (int j = 0; j < kr; j++)
          push(0, 0, 0, req_atn || j < dreq, !req_atn || j < dreq, 0, 0,
               j == kr - 1, n, 0, (j == kr - 1) ? "R4" : "R3");
        for (int i = 0; i < TSU; i++) push(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R5");
        for (int s = 0; s < 4; s++)
          for (int i = 0; i < TSL; i++)
            push(0, 0, 0, 1, 1, !b[2*s+1], !b[2*s], 0, 0, 0, "R5");
        for (int i = 0; i < TP; i++) push(0, 0, 0, 1, 1, !b[7], !b[6], 0, 0, 0, "R6");
      end
      for (int j = 0; j < ko; j++)
        push(0, 0, 0, ok_atn || j < dok, !ok_atn || j < dok, 0, 1, 0, 0, 0, "R7");
      if (ok_atn) begin
        cur_abort = 1;
        push(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R8");
      end else if (ef) begin
        eof_mark(0, 0, 0, "R9");
      end else begin
        for (int i = 0; i < TT; i++) push(0, 0, 0, 1, 1, 0, 1, 0, 0, 0, "R10");
        push(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R12");
      end
    end
    idle(4, "R12");
  endtask

  task automatic play();
    for (int i = 0; i < q_st.size(); i++) begin
      @(negedge clk);
      start = q_st[i]; len = 8'(q_len[i]); eof = q_ef[i]; hd = q_hd[i]; ha = q_ha[i];
      @(posedge clk);
      #1;
      vec++;
      if (data_pull !== q_dp[i] || clk_pull !== q_cp[i] || done !== q_dn[i] ||
          abort !== q_ab[i] || fetch_en !== q_fe[i] ||
          (q_fe[i] && fetch_addr !== 8'(q_fa[i]))) begin
        bad++;
        $display("FAIL %s step %0d: got dp=%b cp=%b done=%b abort=%b fe=%b addr=%0d exp dp=%b cp=%b done=%b abort=%b fe=%b addr=%0d",
                 q_tag[i], i, data_pull, clk_pull, done, abort, fetch_en, fetch_addr,
                 q_dp[i], q_cp[i], q_dn[i], q_ab[i], q_fe[i], q_fa[i]);
      end
    end
    q_st.delete(); q_len.delete(); q_ef.delete(); q_hd.delete(); q_ha.delete();
    q_dp.delete(); q_cp.delete(); q_fe.delete(); q_fa.delete(); q_dn.delete();
    q_ab.delete(); q_tag.delete();
  endtask

  initial begin
    foreach (mem[i]) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    vec++;  // R1 reset state
    if (data_pull !== 0 || clk_pull !== 0 || done !== 0 || abort !== 0 || fetch_en !== 0) begin
      bad++;
      $display("FAIL R1 reset: got dp=%b cp=%b done=%b abort=%b fe=%b exp all 0",
               data_pull, clk_pull, done, abort, fetch_en);
    end
    @(negedge clk) rst_n = 1'b1;
    idle(3, "R1"); play();

    // data requests, EOF mark, stray start while busy
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'hFF;
    xfer(3, 1, 1, 0, 2, 0, 1); play();
    // attention-driven requests, slow host, no end flag -> tail
    mem[0] = 8'h00; mem[1] = 8'h81;
    xfer(2, 0, 5, 1, 0, 0, 0); play();
    // attention during OK -> abort, flag held afterwards
    mem[0] = 8'h5A;
    xfer(1, 1, 0, 0, 1, 1, 0); play();
    // zero length, end flag clear -> mark anyway; clears abort flag
    xfer(0, 0, 0, 0, 0, 0, 0); play();
    // zero length, end flag set
    xfer(0, 1, 0, 0, 0, 0, 0); play();
    // single byte, data ack, tail
    mem[0] = 8'h96;
    xfer(1, 0, 2, 0, 3, 0, 0); play();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule